// File: doc/BRIEF.md
# Three-Decade Synchronous BCD Counter

This block counts enabled clock edges in decimal, from 000 up to 999, and then starts again at 000. It is built from a chain of identical decade stages. Each stage holds one binary-coded decimal digit with bit weights 8-4-2-1. The lowest stage steps on every clock edge while the count enable is high. Each higher stage steps only when the stage below it passes from 9 back to 0.

All flip-flops share one clock. Stages are linked by a carry enable, not by a divided clock. Inside each stage, the next value of every bit follows the toggle rules of a ripple decade, so the digit sequence is 0 through 9. The block has a synchronous clear that zeroes every digit and overrides the enable. It also has an asynchronous active-low reset. A terminal-count flag tells downstream logic that the next enabled edge will roll the counter from 999 to 000. The block is meant for event tallies and decimal readouts. It has no data stream, so every pin is a plain control or status signal.

Top module: `bcd_cascade_counter`

## Requirements
- R1: While `rst_n` is low, or at the clock edge after `clr` is sampled high, every digit reads 0. `clr` wins over `cnt_en`.
- R2: At an edge where `clr` is low and `cnt_en` is low, all digits hold their value.
- R3: At an edge where `clr` is low and `cnt_en` is high, the units digit (bits 3:0 of `digits_o`) advances by one. After 9 it returns to 0.
- R4: Every digit field is an 8-4-2-1 BCD code and never shows a value above 9.
- R5: The tens digit (bits 7:4) and the hundreds digit (bits 11:8) each advance by one, from 9 to 0, exactly at the edges where every lower digit wraps from 9 to 0. At all other edges they hold.
- R6: The counter runs through every value from 000 to 999 in order and goes from 999 to 000 on the next enabled edge.
- R7: `term_cnt_o` is high exactly when all three digits read 9 and `cnt_en` is high. It is combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all decades |
| rst_n | input | 1 | Asynchronous reset, active low, zeroes all digits |
| clr | input | 1 | Synchronous clear to 000, priority over enable |
| cnt_en | input | 1 | Count enable for the units decade |
| digits_o | output | 12 | BCD digits: [3:0] units, [7:4] tens, [11:8] hundreds |
| term_cnt_o | output | 1 | High when the count is 999 and `cnt_en` is high |

## Verification
The hardest case to reach is the hundreds carry at 999 to 000. It needs two chained carries, and it needs the terminal flag, which depends on the enable in the same cycle. The only way to get there from the ports is to walk the counter through all thousand states. The stimulus therefore runs one long enabled sequence from zero and compares every step with a decimal reference. At 999 it drops and raises the enable to test the flag, then takes the final step to see the wrap. The 9-to-0 wraps at 009, 099 and 999 are also the cases that exercise the ripple-style rule for the weight-8 bit.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int BCD_W   = 4;
  localparam int BCD_MAX = 9;
  typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcd_cnt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  output bcd_t digit_o,
  output logic is_nine_o,
  output logic carry_o
);
  bcd_t q, d;
  logic fall_w1;  // weight-1 bit passes 1 -> 0 this step
  logic fall_w2;  // weight-2 bit passes 1 -> 0 this step

  always_comb begin
    fall_w1 = step_i & q[0];
    fall_w2 = fall_w1 & ~q[3] & q[1];
    d[0] = q[0] ^ step_i;
    // weight 2 toggles on a weight-1 fall, but is held at 0 while weight 8 is set
    d[1] = (fall_w1 & ~q[3]) ? ~q[1] : q[1];
    d[2] = q[2] ^ fall_w2;
    // weight 8 sets on the fall after 7 and clears on the following fall
    if (fall_w1) d[3] = q[3] ? 1'b0 : (q[1] & q[2]);
    else         d[3] = q[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr_i) q <= '0;
    else            q <= d;
  end

  assign digit_o   = q;
  assign is_nine_o = (q == bcd_t'(BCD_MAX));
  assign carry_o   = fall_w1 & q[3];
endmodule

// File: rtl/bcd_cascade_counter.sv
module bcd_cascade_counter
  import bcd_cnt_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  localparam int OUT_W = NUM_DIGITS * BCD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cnt_en,
  output logic [OUT_W-1:0] digits_o,
  output logic             term_cnt_o
);
  logic [NUM_DIGITS:0]   step_chain;
  logic [NUM_DIGITS-1:0] nine_vec;

  assign step_chain[0] = cnt_en;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
    bcd_t dig;
    bcd_decade u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .step_i    (step_chain[g]),
      .digit_o   (dig),
      .is_nine_o (nine_vec[g]),
      .carry_o   (step_chain[g+1])
    );
    assign digits_o[g*BCD_W +: BCD_W] = dig;
  end

  assign term_cnt_o = cnt_en & (&nine_vec);
endmodule

// File: rtl/bcd_cascade_counter_chk.sv
module bcd_cascade_counter_chk
  import bcd_cnt_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  localparam int OUT_W = NUM_DIGITS * BCD_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             cnt_en,
  input logic [OUT_W-1:0] digits_o,
  input logic             term_cnt_o
);
  function automatic logic lower_all_nine(input logic [OUT_W-1:0] v, input int k);
    logic r;
    r = 1'b1;
    for (int j = 0; j < NUM_DIGITS; j++)
      if (j < k && v[j*BCD_W +: BCD_W] != bcd_t'(BCD_MAX)) r = 1'b0;
    return r;
  endfunction

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> digits_o == '0); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !cnt_en) |=> $stable(digits_o)); // R2

  AST_UNITS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt_en && digits_o[BCD_W-1:0] != bcd_t'(BCD_MAX))
      |=> digits_o[BCD_W-1:0] == $past(digits_o[BCD_W-1:0]) + 1'b1); // R3

  AST_UNITS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt_en && digits_o[BCD_W-1:0] == bcd_t'(BCD_MAX))
      |=> digits_o[BCD_W-1:0] == '0); // R3

  AST_TERM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt_o == (cnt_en && lower_all_nine(digits_o, NUM_DIGITS))); // R7

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_chk
    AST_BCD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      digits_o[g*BCD_W +: BCD_W] <= bcd_t'(BCD_MAX)); // R4
    if (g > 0) begin : g_hi
      AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(cnt_en && lower_all_nine(digits_o, g)))
          |=> $stable(digits_o[g*BCD_W +: BCD_W])); // R5
      AST_HIGH_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_en && lower_all_nine(digits_o, g))
          |=> digits_o[g*BCD_W +: BCD_W] ==
              (($past(digits_o[g*BCD_W +: BCD_W]) == bcd_t'(BCD_MAX)) ? bcd_t'(0)
               : bcd_t'($past(digits_o[g*BCD_W +: BCD_W]) + 1'b1))); // R5
    end
  end
endmodule

bind bcd_cascade_counter bcd_cascade_counter_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_en(cnt_en),
  .digits_o(digits_o), .term_cnt_o(term_cnt_o)
);

// File: tb/bcd_cascade_counter_test.sv
module bcd_cascade_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic cnt_en = 1'b0;
  logic [11:0] digits_o;
  logic term_cnt_o;
  int n_checks = 0;
  int n_errors = 0;
  int model = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bcd_cascade_counter uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_en(cnt_en),
    .digits_o(digits_o), .term_cnt_o(term_cnt_o)
  );

  function automatic logic [11:0] to_bcd(input int v);
    return {4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one edge, updating the reference model from the pin values
  task automatic step();
    tick();
    if (clr) model = 0;
    else if (cnt_en) model = (model + 1) % 1000;
  endtask

  task automatic t_reset();
    check("R1 reset", digits_o, 12'h000);
    check("R7 reset flag", {11'b0, term_cnt_o}, 12'h000);
    rst_n = 1'b1;
    tick();
    check("R2 idle after reset", digits_o, 12'h000);
  endtask

  task automatic t_count_low();
    cnt_en = 1'b1;
    for (int i = 0; i < 25; i++) begin
      step();
      check("R3 R5 early count", digits_o, to_bcd(model));
    end
    check("R5 tens after 25", digits_o, 12'h025);
  endtask

  task automatic t_hold();
    cnt_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      check("R2 hold", digits_o, 12'h025);
    end
  endtask

  task automatic t_clear();
    cnt_en = 1'b1;
    for (int i = 0; i < 22; i++) step();
    check("R5 value 047", digits_o, 12'h047);
    clr = 1'b1;
    step();
    check("R1 clear beats enable", digits_o, 12'h000);
    clr = 1'b0;
    step();
    check("R3 count after clear", digits_o, 12'h001);
    clr = 1'b1;
    cnt_en = 1'b0;
    step();
    check("R1 clear while idle", digits_o, 12'h000);
    clr = 1'b0;
  endtask

  task automatic t_full_run();
    int bad = 0;
    cnt_en = 1'b1;
    while (model != 999) begin
      step();
      if (digits_o !== to_bcd(model)) bad++;
      if (model == 10)  check("R5 tens wrap 009->010", digits_o, 12'h010);
      if (model == 100) check("R5 hundreds 099->100", digits_o, 12'h100);
      if (model == 998) check("R7 flag low at 998", {11'b0, term_cnt_o}, 12'h000);
    end
    check("R6 R4 full sequence mismatches", 12'(bad), 12'h000);
    check("R6 at 999", digits_o, 12'h999);
    check("R7 flag at 999 enabled", {11'b0, term_cnt_o}, 12'h001);
    cnt_en = 1'b0;
    #1;
    check("R7 flag needs enable", {11'b0, term_cnt_o}, 12'h000);
    step();
    check("R2 hold at 999", digits_o, 12'h999);
    cnt_en = 1'b1;
    step();
    check("R6 wrap 999->000", digits_o, 12'h000);
    check("R7 flag after wrap", {11'b0, term_cnt_o}, 12'h000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_count_low();
    t_hold();
    t_clear();
    t_full_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule